// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block works out the 32-bit operand address for register-indirect addressing with an index register. It covers both the short one-word extension format and the long format. The long format adds optional base and outer displacements, can suppress the base or the index, and can insert one 32-bit memory read. That read is the memory indirection, and the index is applied either before it or after it.

A pulse on `start` captures the base value. The base is an address register value or the address of the extension word, chosen by `pc_base`. The block then pulls extension words one at a time over a valid/ready handshake. It drives a register-file read port to get the index register, and issues at most one memory read over a request/acknowledge port. Each sequence ends with exactly one single-cycle pulse:

- `done`, with the address on `ea`;
- `illegal`, for a reserved encoding;
- `fault`, when the memory read returns an error.

Top module: `idx_ea_calc`

## Requirements
- R1: With extension bit 8 at 0 (short format), the result is base + sign-extended bits 7..0 + scaled index, after exactly one extension word and no memory read.
- R2: Extension bit 15 picks the index file (0 data, 1 address) and bits 14..12 the register number; these appear on `rf_is_addr` and `rf_num`.
- R3: Extension bit 11 at 0 takes the low 16 bits of the index register sign-extended; at 1 it takes all 32 bits.
- R4: Extension bits 10..9 shift the index left by 0, 1, 2 or 3 before it is added.
- R5: In long format (bit 8 at 1), bit 7 at 1 replaces the base with zero and bit 6 at 1 drops the index.
- R6: Long-format bits 5..4 size the base displacement: 01 none, 10 one word sign-extended, 11 two words with the high half first; 00 gives `illegal` with no memory read.
- R7: Long-format bits 1..0 at 00 give no memory read; the result is base + base displacement + index.
- R8: With bit 2 at 0 and bits 1..0 nonzero, the read address is base + base displacement + index, and the result is the read data + outer displacement; `mem_addr` holds until `mem_ack`.
- R9: With bit 2 at 1, the read address is base + base displacement, and the result is the read data + index + outer displacement.
- R10: Bits 1..0 size the outer displacement: 01 none, 10 one word sign-extended, 11 two words with the high half first, taken after the base displacement words.
- R11: With `pc_base` at 1 at `start`, the base is `pc_val` rather than `areg_val`.
- R12: A read answered with `mem_err` at 1 ends the sequence with `fault` and without `done`.
- R13: Long format with bit 2 at 1 and bits 1..0 at 00 gives `illegal`.
- R14: `done`, `illegal` and `fault` are single-cycle and mutually exclusive. Each returns the block to idle, where `ext_ready` and `mem_req` are low. A `start` while busy is ignored. Word gaps and read latency do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (ignored while busy) |
| pc_base | input | 1 | 1 selects `pc_val` as base |
| areg_val | input | AW | Address register base value |
| pc_val | input | AW | Address of the extension word |
| ext_valid | input | 1 | Extension word offered |
| ext_ready | output | 1 | Block is waiting for an extension word |
| ext_data | input | 16 | Extension word |
| rf_is_addr | output | 1 | Index file select (1 address, 0 data) |
| rf_num | output | 3 | Index register number |
| rf_data | input | AW | Index register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Read response present |
| mem_err | input | 1 | Response is an error |
| mem_rdata | input | AW | Read data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Result pulse |
| ea | output | AW | Computed address, valid with `done` |
| illegal | output | 1 | Reserved encoding pulse |
| fault | output | 1 | Read error pulse |

## Verification
The bench builds the block with the default AW of 32. This is the width at which a two-word displacement fills the whole datapath and the carries into the top bits are visible. The bench register file holds data registers with a negative low half and address registers with a positive one. That makes word and long index sizes give different sums under every scale. The table runs every base and outer displacement size, both indirection orderings and both reserved encodings. A rerun with stalled words, slow read responses and `start` held high shows the result is independent of handshake timing.

// File: rtl/idx_ea_calc.sv
module idx_ea_calc #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pc_base,
  input  logic [AW-1:0] areg_val,
  input  logic [AW-1:0] pc_val,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic [15:0]   ext_data,
  output logic          rf_is_addr,
  output logic [2:0]    rf_num,
  input  logic [AW-1:0] rf_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          illegal,
  output logic          fault
);
  typedef enum logic [2:0] {S_IDLE, S_EXT, S_BDH, S_BDL, S_IDX, S_MEM, S_ODH, S_ODL} st_t;

  st_t           st;
  logic [15:0]   ew;
  logic [15:0]   hi;
  logic [AW-1:0] acc;
  logic          memd;

  wire xfer = ext_valid & ext_ready;
  wire is_full = ew[8];
  wire post = ew[2];
  wire [1:0] od = ew[1:0];

  wire [AW-1:0] d8   = AW'($signed(ext_data[7:0]));
  wire [AW-1:0] d16  = AW'($signed(ext_data));
  wire [AW-1:0] d32  = AW'($signed({hi, ext_data}));
  wire [AW-1:0] raw  = ew[11] ? rf_data : AW'($signed(rf_data[15:0]));
  wire [AW-1:0] idx  = raw << ew[10:9];
  wire          use_idx = !is_full || !ew[6];

  assign ext_ready  = (st == S_EXT) || (st == S_BDH) || (st == S_BDL) || (st == S_ODH) || (st == S_ODL);
  assign mem_req    = (st == S_MEM);
  assign mem_addr   = acc;
  assign busy       = (st != S_IDLE);
  assign ea         = acc;
  assign rf_is_addr = ew[15];
  assign rf_num     = ew[14:12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ew      <= '0;
      hi      <= '0;
      acc     <= '0;
      memd    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      fault   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      fault   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          acc  <= pc_base ? pc_val : areg_val;
          memd <= 1'b0;
          st   <= S_EXT;
        end
        S_EXT: if (xfer) begin
          ew <= ext_data;
          if (!ext_data[8]) begin
            acc <= acc + d8;
            st  <= S_IDX;
          end else if (ext_data[5:4] == 2'b00 || (ext_data[2] && ext_data[1:0] == 2'b00)) begin
            illegal <= 1'b1;
            st      <= S_IDLE;
          end else begin
            if (ext_data[7]) acc <= '0;
            case (ext_data[5:4])
              2'b10:   st <= S_BDL;
              2'b11:   st <= S_BDH;
              default: st <= ext_data[2] ? S_MEM : S_IDX;
            endcase
          end
        end
        S_BDH: if (xfer) begin
          hi <= ext_data;
          st <= S_BDL;
        end
        S_BDL: if (xfer) begin
          acc <= acc + (ew[4] ? d32 : d16);
          st  <= post ? S_MEM : S_IDX;
        end
        S_IDX: begin
          if (use_idx) acc <= acc + idx;
          if (!is_full || od == 2'b00) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (!memd) begin
            st <= S_MEM;
          end else begin
            case (od)
              2'b10:   st <= S_ODL;
              2'b11:   st <= S_ODH;
              default: begin done <= 1'b1; st <= S_IDLE; end
            endcase
          end
        end
        S_MEM: if (mem_ack) begin
          if (mem_err) begin
            fault <= 1'b1;
            st    <= S_IDLE;
          end else begin
            acc  <= mem_rdata;
            memd <= 1'b1;
            if (post) st <= S_IDX;
            else begin
              case (od)
                2'b10:   st <= S_ODL;
                2'b11:   st <= S_ODH;
                default: begin done <= 1'b1; st <= S_IDLE; end
              endcase
            end
          end
        end
        S_ODH: if (xfer) begin
          hi <= ext_data;
          st <= S_ODL;
        end
        S_ODL: if (xfer) begin
          acc  <= acc + (ew[0] ? d32 : d16);
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_calc_chk.sv
module idx_ea_calc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic          fault,
  input logic          ext_valid,
  input logic          ext_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, fault})); // R14
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R14
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || illegal || fault) |-> !busy); // R14
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ext_ready && !mem_req)); // R14
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8
  AST_NO_FETCH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ext_ready); // R9
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(ext_valid && ext_ready)); // R6
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(mem_req && mem_ack && mem_err)); // R12
endmodule

bind idx_ea_calc idx_ea_calc_chk #(.AW(AW)) u_chk (.*);

// File: tb/idx_ea_calc_bench.sv
module idx_ea_calc_bench;
  localparam int AW = 32;

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] ew;
    logic [63:0] w;
    logic        pcb;
    logic [31:0] base;
    logic [31:0] md;
    logic        merr;
    logic [1:0]  kind;
    logic [31:0] ea;
    logic [31:0] ma;
    logic [3:0]  nw;
    logic [1:0]  nr;
  } vec_t;

  // kind: 0 done, 1 illegal, 2 fault
  localparam vec_t VT [12] = '{
    '{8'd1,  16'hDCF0, 64'h0, 1'b0, 32'h0001_0000, 32'h0, 1'b0, 2'd0, 32'h0001_93F0, 32'h0, 4'd1, 2'd0}, // R1 R2 R4
    '{8'd3,  16'h307F, 64'h0, 1'b0, 32'h0004_0000, 32'h0, 1'b0, 2'd0, 32'h0003_8082, 32'h0, 4'd1, 2'd0}, // R3
    '{8'd11, 16'h1E04, 64'h0, 1'b1, 32'h0000_8000, 32'h0, 1'b0, 2'd0, 32'h000C_800C, 32'h0, 4'd1, 2'd0}, // R11 R4
    '{8'd7,  16'hAB20, 64'hFFFE_0000_0000_0000, 1'b0, 32'h0010_0000, 32'h0, 1'b0, 2'd0, 32'h0010_43FE, 32'h0, 4'd2, 2'd0}, // R7 R6
    '{8'd5,  16'h01F0, 64'h1234_5678_0000_0000, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b0, 2'd0, 32'h1234_5678, 32'h0, 4'd3, 2'd0}, // R5 R6
    '{8'd8,  16'h0911, 64'h0, 1'b0, 32'h2000_0000, 32'hCAFE_0000, 1'b0, 2'd0, 32'hCAFE_0000, 32'h2001_8000, 4'd1, 2'd1}, // R8
    '{8'd10, 16'h9522, 64'h0010_8000_0000_0000, 1'b0, 32'h0000_4000, 32'h0010_0000, 1'b0, 2'd0, 32'h000F_8000, 32'h0000_C410, 4'd3, 2'd1}, // R10 R8
    '{8'd9,  16'h7B37, 64'h0001_0000_0000_0020, 1'b0, 32'h0000_0100, 32'h0300_0000, 1'b0, 2'd0, 32'h0303_002E, 32'h0001_0100, 4'd5, 2'd1}, // R9 R10
    '{8'd5,  16'h01D5, 64'h0, 1'b0, 32'h7777_0000, 32'h55AA_0000, 1'b0, 2'd0, 32'h55AA_0000, 32'h0, 4'd1, 2'd1}, // R5 R9
    '{8'd6,  16'h0100, 64'h0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd1, 32'h0, 32'h0, 4'd1, 2'd0}, // R6
    '{8'd13, 16'h0114, 64'h0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd1, 32'h0, 32'h0, 4'd1, 2'd0}, // R13
    '{8'd12, 16'h0911, 64'h0, 1'b0, 32'h2000_0000, 32'h0, 1'b1, 2'd2, 32'h0, 32'h2001_8000, 4'd1, 2'd1}  // R12
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, pc_base = 1'b0;
  logic [AW-1:0] areg_val = '0, pc_val = '0;
  logic          ext_valid = 1'b0;
  logic          ext_ready;
  logic [15:0]   ext_data = '0;
  logic          rf_is_addr;
  logic [2:0]    rf_num;
  logic [AW-1:0] rf_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0, mem_err = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic          busy, done, illegal, fault;
  logic [AW-1:0] ea;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // Register file model: data regs have a negative low half, address regs a positive one (R2, R3)
  assign rf_data = rf_is_addr ? (32'h0000_2000 + (32'(rf_num) << 8)) : (32'h0001_8000 + 32'(rf_num));

  idx_ea_calc #(.AW(AW)) u_idx_ea_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_base(pc_base),
    .areg_val(areg_val), .pc_val(pc_val),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_data(ext_data),
    .rf_is_addr(rf_is_addr), .rf_num(rf_num), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea),
    .illegal(illegal), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit gap, input int lat, input bit keep,
                     output logic [1:0] k, output logic [31:0] e, output logic [31:0] ma,
                     output int nw, output int nr);
    int  widx = 0;
    int  mw = 0;
    bit  px = 1'b0;
    bit  tog = 1'b0;
    bit  fin = 1'b0;
    k = 2'd3; e = '0; ma = '0; nw = 0; nr = 0;
    @(negedge clk);
    pc_base  = v.pcb;
    areg_val = v.pcb ? 32'hDEAD_0000 : v.base;
    pc_val   = v.pcb ? v.base : 32'hBAD0_0000;
    start    = 1'b1;
    ext_valid = 1'b1;
    ext_data  = v.ew;
    for (int i = 0; i < 80 && !fin; i++) begin
      @(negedge clk);
      if (!keep) start = 1'b0;
      if (px) widx++;
      tog = ~tog;
      ext_valid = gap ? tog : 1'b1;
      ext_data  = (widx == 0) ? v.ew : (widx <= 4) ? v.w[63 - 16*(widx-1) -: 16] : 16'h0;
      px = ext_valid && ext_ready;
      if (mem_req) begin
        mw++;
        mem_ack   = (mw > lat);
        mem_rdata = v.md;
        mem_err   = v.merr;
        if (mem_ack) begin nr++; ma = mem_addr; end
      end else begin
        mem_ack = 1'b0;
        mw = 0;
      end
      if (done || illegal || fault) begin
        fin = 1'b1;
        start = 1'b0;
        k = done ? 2'd0 : illegal ? 2'd1 : 2'd2;
        e = ea;
      end
    end
    nw = widx;
    ext_valid = 1'b0;
    mem_ack = 1'b0;
    if (!fin) chk(1'b0, "R14", "sequence timeout", 32'h0, 32'h1);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL R14 watchdog actual %h expected %h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  k;
    logic [31:0] e, ma;
    int          nw, nr;
    string       r;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(!busy, "R14", "busy after reset", 32'(busy), 32'h0);
    chk(!ext_ready && !mem_req, "R14", "ports quiet after reset", {ext_ready, mem_req}, 32'h0);
    chk(!done && !illegal && !fault, "R14", "no outcome after reset", {done, illegal, fault}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      run(VT[i], 1'b0, 0, 1'b0, k, e, ma, nw, nr);
      r = $sformatf("R%0d", VT[i].req);
      chk(k == VT[i].kind, r, $sformatf("vec %0d outcome", i), 32'(k), 32'(VT[i].kind));
      if (VT[i].kind == 2'd0)
        chk(e == VT[i].ea, r, $sformatf("vec %0d address", i), e, VT[i].ea);
      chk(nw == int'(VT[i].nw), r, $sformatf("vec %0d words used", i), nw, 32'(VT[i].nw));
      chk(nr == int'(VT[i].nr), r, $sformatf("vec %0d reads", i), nr, 32'(VT[i].nr));
      if (VT[i].nr != 0)
        chk(ma == VT[i].ma, r, $sformatf("vec %0d read address", i), ma, VT[i].ma);
      @(negedge clk);
      chk(!busy, "R14", $sformatf("vec %0d idle after end", i), 32'(busy), 32'h0);
    end

    // R14 and R8: stalled words, slow read, start held high, result unchanged (post-index long case, R9)
    run(VT[7], 1'b1, 3, 1'b1, k, e, ma, nw, nr);
    chk(k == 2'd0, "R14", "stalled run outcome", 32'(k), 32'h0);
    chk(e == 32'h0303_002E, "R14", "stalled run address", e, 32'h0303_002E);
    chk(nw == 5, "R10", "stalled run words used", nw, 32'd5);
    chk(ma == 32'h0001_0100, "R8", "slow read address held", ma, 32'h0001_0100);

    // R8 pre-index with slow read and gaps
    run(VT[6], 1'b1, 2, 1'b0, k, e, ma, nw, nr);
    chk(e == 32'h000F_8000, "R8", "pre-index slow address", e, 32'h000F_8000);
    chk(ma == 32'h0000_C410, "R8", "pre-index slow read address", ma, 32'h0000_C410);

    // R12 fault after latency, then recovery with a clean short-format run (R1)
    run(VT[11], 1'b0, 2, 1'b0, k, e, ma, nw, nr);
    chk(k == 2'd2, "R12", "late error outcome", 32'(k), 32'h2);
    run(VT[0], 1'b0, 0, 1'b0, k, e, ma, nw, nr);
    chk(e == 32'h0001_93F0, "R1", "run after fault", e, 32'h0001_93F0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule